// File: doc/BRIEF.md
# Self-Configuring Scratch-Pad DMA Channel

This block is a single physical DMA channel with no host-programmable registers. When one of its five logical channels is started, the channel reads that logical channel's transfer descriptor (start address, word count, direction) from a small table in a subsystem scratch-pad memory. It then moves the requested number of words between external memory and a fixed data window in the scratch pad. The window has no request/acknowledge handshake; it accepts or supplies one word whenever it is accessed.

Logical channels time-share the one engine. A start that arrives while the engine is busy is remembered in a pending mask. When the engine goes idle, the lowest-numbered pending logical channel is served next. Logical channel 4 is reserved for program loading and always copies from external memory into the scratch pad. External memory is reached through a request/acknowledge port toward an arbiter, which owns all memory timing.

Top module: `sp_desc_dma`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done`, `mem_req`, `sp_rd` and `sp_wr` are all low.
- R2: After logical channel i is selected, the channel reads scratch-pad words DESC_BASE+3i, +3i+1 and +3i+2 on three consecutive cycles, as address, word count and direction in that order (DESC_BASE defaults to 0).
- R3: With direction bit 0 equal to 0, the channel performs `count` memory reads at consecutive addresses from the descriptor address upward. It writes each returned word, in order, to the scratch-pad window DATA_BASE+i (default 0x20+i).
- R4: With direction bit 0 equal to 1, the channel reads the window DATA_BASE+i `count` times. It writes each word, in order, to external memory at consecutive addresses from the descriptor address upward.
- R5: A word count of zero raises `done` five clock edges after the start is sampled, with no memory request at all.
- R6: Logical channel 4 always transfers from memory to the scratch pad, whatever its direction word holds.
- R7: `done` is a one-cycle pulse carrying the finished logical index on `done_idx`, and `busy` is low on the following cycle.
- R8: Starts arriving while busy are queued; among queued channels the lowest index is served first.
- R9: Logical transfers never interleave: all window traffic of one finishes before the next begins.
- R10: A start with an index of 5 or more is ignored.
- R11: Once `mem_req` is raised, it stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vld | input | 1 | Start request for one logical channel |
| start_idx | input | IDXW | Logical channel to start |
| sp_rd | output | 1 | Scratch-pad read strobe (data returned next cycle) |
| sp_wr | output | 1 | Scratch-pad write strobe |
| sp_addr | output | SP_AW | Scratch-pad word address |
| sp_wdata | output | DW | Scratch-pad write data |
| sp_rdata | input | DW | Scratch-pad read data, one cycle after `sp_rd` |
| mem_req | output | 1 | External memory request toward the arbiter |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | MEM_AW | External memory word address |
| mem_wdata | output | DW | External memory write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | DW | External memory read data |
| done | output | 1 | Logical transfer finished (one cycle) |
| done_idx | output | IDXW | Logical channel that finished |
| busy | output | 1 | Engine occupied by a logical transfer |

## Verification
The hardest state to reach from the ports is a pending mask with several bits set at the moment the engine goes idle. That state is what shows lowest-first selection and the absence of interleaving. The bench starts the program-load channel and then, on the next two cycles, starts channels 2 and 0 while the first transfer is still fetching its descriptor. It then checks both the order of completion pulses and the grouping of window writes. Around that, a sweep covers every logical channel with counts of 0, 1 and 4, both direction words, and acknowledge delays of 0 to 2 cycles.

// File: rtl/spdma_pkg.sv
package spdma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FADDR,
    S_FCNT,
    S_FDIR,
    S_XFER,
    S_DONE
  } seq_st_t;

  typedef enum logic {
    DIR_M2S = 1'b0,
    DIR_S2M = 1'b1
  } xdir_t;

  localparam logic [1:0] PH_0 = 2'd0;
  localparam logic [1:0] PH_1 = 2'd1;
  localparam logic [1:0] PH_2 = 2'd2;

endpackage

// File: rtl/spdma_pending.sv
module spdma_pending #(
  parameter int NLCH = 5,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_vld,
  input  logic [IDXW-1:0] start_idx,
  input  logic            take,
  input  logic [IDXW-1:0] take_idx,
  output logic [NLCH-1:0] pend,
  output logic            any_pend,
  output logic [IDXW-1:0] pick_idx
);

  logic [NLCH-1:0] set_v;
  logic [NLCH-1:0] clr_v;

  for (genvar g = 0; g < NLCH; g++) begin : g_bit
    assign set_v[g] = start_vld && (start_idx == IDXW'(g));
    assign clr_v[g] = take && (take_idx == IDXW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_v) | set_v;
  end

  assign any_pend = |pend;

  always_comb begin
    pick_idx = '0;
    for (int i = NLCH - 1; i >= 0; i--) begin
      if (pend[i]) pick_idx = IDXW'(i);
    end
  end

  // R10: out-of-range starts leave an empty mask empty
  a_r10_bad_idx_ignored: assert property (@(posedge clk) disable iff (rst)
    (pend == '0 && start_vld && int'(start_idx) >= NLCH) |=> (pend == '0));

  // R8: the picked channel is pending and nothing lower is
  a_r8_pick_lowest: assert property (@(posedge clk) disable iff (rst)
    any_pend |-> (pend[pick_idx] && ((pend & ((NLCH'(1) << pick_idx) - NLCH'(1))) == '0)));

  // R8: a taken channel leaves the mask unless restarted in the same cycle
  a_r8_take_clears: assert property (@(posedge clk) disable iff (rst)
    (take && !(start_vld && start_idx == take_idx)) |=> !pend[$past(take_idx)]);

endmodule

// File: rtl/spdma_seq.sv
module spdma_seq
  import spdma_pkg::*;
#(
  parameter int DW        = 16,
  parameter int MEM_AW    = 16,
  parameter int SP_AW     = 8,
  parameter int NLCH      = 5,
  parameter int IDXW      = 3,
  parameter int DESC_BASE = 0,
  parameter int DATA_BASE = 32,
  parameter int PROG_LCH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_pend,
  input  logic [IDXW-1:0]   pick_idx,
  output logic              take,
  output logic [IDXW-1:0]   take_idx,
  output logic              sp_rd,
  output logic              sp_wr,
  output logic [SP_AW-1:0]  sp_addr,
  output logic [DW-1:0]     sp_wdata,
  input  logic [DW-1:0]     sp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              done,
  output logic [IDXW-1:0]   done_idx,
  output logic              busy
);

  localparam int DESC_WORDS = 3;

  seq_st_t           state;
  logic [IDXW-1:0]   cur_idx;
  logic [MEM_AW-1:0] addr_q;
  logic [DW-1:0]     cnt_q;
  xdir_t             dir_q;
  logic [1:0]        ph;
  logic [DW-1:0]     buf_q;
  logic [SP_AW-1:0]  win_addr;
  logic              last_word;

  function automatic logic [SP_AW-1:0] desc_at(input logic [IDXW-1:0] idx, input int word);
    return SP_AW'(DESC_BASE + DESC_WORDS * int'(idx) + word);
  endfunction

  assign win_addr  = SP_AW'(DATA_BASE + int'(cur_idx));
  assign last_word = (cnt_q == DW'(1));

  // Port decode: every output is a function of registered state only
  always_comb begin
    take    = 1'b0;
    sp_rd   = 1'b0;
    sp_wr   = 1'b0;
    sp_addr = '0;
    mem_req = 1'b0;
    unique case (state)
      S_IDLE: if (any_pend) begin
        take    = 1'b1;
        sp_rd   = 1'b1;
        sp_addr = desc_at(pick_idx, 0);
      end
      S_FADDR: begin
        sp_rd   = 1'b1;
        sp_addr = desc_at(cur_idx, 1);
      end
      S_FCNT: begin
        sp_rd   = 1'b1;
        sp_addr = desc_at(cur_idx, 2);
      end
      S_XFER: begin
        if (dir_q == DIR_M2S) begin
          if (ph == PH_0) mem_req = 1'b1;
          else begin
            sp_wr   = 1'b1;
            sp_addr = win_addr;
          end
        end else begin
          if (ph == PH_0) begin
            sp_rd   = 1'b1;
            sp_addr = win_addr;
          end else if (ph == PH_2) begin
            mem_req = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign take_idx  = pick_idx;
  assign sp_wdata  = buf_q;
  assign mem_we    = (dir_q == DIR_S2M);
  assign mem_addr  = addr_q;
  assign mem_wdata = buf_q;
  assign done      = (state == S_DONE);
  assign done_idx  = cur_idx;
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cur_idx <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      dir_q   <= DIR_M2S;
      ph      <= PH_0;
      buf_q   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (any_pend) begin
          cur_idx <= pick_idx;
          state   <= S_FADDR;
        end
        S_FADDR: begin
          addr_q <= sp_rdata[MEM_AW-1:0];
          state  <= S_FCNT;
        end
        S_FCNT: begin
          cnt_q <= sp_rdata;
          state <= S_FDIR;
        end
        S_FDIR: begin
          dir_q <= (int'(cur_idx) == PROG_LCH) ? DIR_M2S : xdir_t'(sp_rdata[0]);
          ph    <= PH_0;
          state <= (cnt_q == '0) ? S_DONE : S_XFER;
        end
        S_XFER: begin
          if (dir_q == DIR_M2S) begin
            if (ph == PH_0) begin
              if (mem_ack) begin
                buf_q <= mem_rdata;
                ph    <= PH_1;
              end
            end else begin
              addr_q <= addr_q + MEM_AW'(1);
              cnt_q  <= cnt_q - DW'(1);
              ph     <= PH_0;
              if (last_word) state <= S_DONE;
            end
          end else begin
            if (ph == PH_0) begin
              ph <= PH_1;
            end else if (ph == PH_1) begin
              buf_q <= sp_rdata;
              ph    <= PH_2;
            end else if (mem_ack) begin
              addr_q <= addr_q + MEM_AW'(1);
              cnt_q  <= cnt_q - DW'(1);
              ph     <= PH_0;
              if (last_word) state <= S_DONE;
            end
          end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: a request is held unchanged until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7: completion is a single-cycle pulse followed by an idle engine
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R9: memory and scratch-pad sides are never driven in the same cycle
  a_r9_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (!sp_rd && !sp_wr));

  // R6: the program-load channel never writes external memory
  a_r6_prog_reads_only: assert property (@(posedge clk) disable iff (rst)
    (busy && int'(cur_idx) == PROG_LCH && mem_req) |-> !mem_we);

  // R1: nothing is active on the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !mem_req && !sp_wr));

endmodule

// File: rtl/sp_desc_dma.sv
module sp_desc_dma #(
  parameter int DW        = 16,
  parameter int MEM_AW    = 16,
  parameter int SP_AW     = 8,
  parameter int NLCH      = 5,
  parameter int DESC_BASE = 0,
  parameter int DATA_BASE = 32,
  parameter int PROG_LCH  = 4,
  localparam int IDXW     = (NLCH > 1) ? $clog2(NLCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_vld,
  input  logic [IDXW-1:0]   start_idx,
  output logic              sp_rd,
  output logic              sp_wr,
  output logic [SP_AW-1:0]  sp_addr,
  output logic [DW-1:0]     sp_wdata,
  input  logic [DW-1:0]     sp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              done,
  output logic [IDXW-1:0]   done_idx,
  output logic              busy
);

  logic [NLCH-1:0] pend;
  logic            any_pend;
  logic [IDXW-1:0] pick_idx;
  logic            take;
  logic [IDXW-1:0] take_idx;

  spdma_pending #(
    .NLCH (NLCH),
    .IDXW (IDXW)
  ) u_pend (
    .clk       (clk),
    .rst       (rst),
    .start_vld (start_vld),
    .start_idx (start_idx),
    .take      (take),
    .take_idx  (take_idx),
    .pend      (pend),
    .any_pend  (any_pend),
    .pick_idx  (pick_idx)
  );

  spdma_seq #(
    .DW        (DW),
    .MEM_AW    (MEM_AW),
    .SP_AW     (SP_AW),
    .NLCH      (NLCH),
    .IDXW      (IDXW),
    .DESC_BASE (DESC_BASE),
    .DATA_BASE (DATA_BASE),
    .PROG_LCH  (PROG_LCH)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .any_pend  (any_pend),
    .pick_idx  (pick_idx),
    .take      (take),
    .take_idx  (take_idx),
    .sp_rd     (sp_rd),
    .sp_wr     (sp_wr),
    .sp_addr   (sp_addr),
    .sp_wdata  (sp_wdata),
    .sp_rdata  (sp_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .done      (done),
    .done_idx  (done_idx),
    .busy      (busy)
  );

endmodule

// File: tb/tb_sp_desc_dma.sv
module tb_sp_desc_dma;

  localparam int CLK_P = 10;
  localparam int LOGN  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_vld = 1'b0;
  logic [2:0]  start_idx = '0;
  logic        sp_rd, sp_wr;
  logic [7:0]  sp_addr;
  logic [15:0] sp_wdata;
  logic [15:0] sp_rdata = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        done, busy;
  logic [2:0]  done_idx;

  sp_desc_dma dut (
    .clk(clk), .rst(rst), .start_vld(start_vld), .start_idx(start_idx),
    .sp_rd(sp_rd), .sp_wr(sp_wr), .sp_addr(sp_addr), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .done_idx(done_idx), .busy(busy)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;

  logic [15:0] dsc [16];
  logic [15:0] seq [8];
  logic [7:0]  rd_a [LOGN];
  logic [7:0]  wl_a [LOGN];
  logic [15:0] wl_d [LOGN];
  logic [15:0] mw_a [LOGN];
  logic [15:0] mw_d [LOGN];
  logic [2:0]  dl   [LOGN];
  int nr = 0, nw = 0, nmr = 0, nmw = 0, nd = 0, wc = 0, hold_err = 0;
  logic pv_req = 1'b0, pv_ack = 1'b0, pv_we = 1'b0;
  logic [15:0] pv_addr = '0, pv_wd = '0;

  function automatic logic [15:0] ext_word(input logic [15:0] a);
    return 16'h5000 ^ (a * 16'd7);
  endfunction

  function automatic logic [15:0] win_word(input int ch, input int k);
    return 16'hA000 | 16'(ch << 8) | 16'(k);
  endfunction

  initial for (int i = 0; i < 8; i++) seq[i] = '0;

  // Scratch-pad model: descriptor table, window streams, write log
  always @(posedge clk) begin
    if (sp_rd) begin
      rd_a[nr % LOGN] <= sp_addr;
      nr <= nr + 1;
      if (sp_addr >= 8'h20 && sp_addr < 8'h25) begin
        sp_rdata <= win_word(int'(sp_addr - 8'h20), int'(seq[sp_addr - 8'h20]));
        seq[sp_addr - 8'h20] <= seq[sp_addr - 8'h20] + 16'd1;
      end else if (sp_addr < 8'd16) begin
        sp_rdata <= dsc[sp_addr[3:0]];
      end else begin
        sp_rdata <= 16'hDEAD;
      end
    end
    if (sp_wr) begin
      wl_a[nw % LOGN] <= sp_addr;
      wl_d[nw % LOGN] <= sp_wdata;
      nw <= nw + 1;
    end
  end

  // External memory model with ack delay `lat`
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wc >= lat) begin
        mem_ack <= 1'b1;
        wc <= 0;
        if (!mem_we) begin
          mem_rdata <= ext_word(mem_addr);
          nmr <= nmr + 1;
        end else begin
          mw_a[nmw % LOGN] <= mem_addr;
          mw_d[nmw % LOGN] <= mem_wdata;
          nmw <= nmw + 1;
        end
      end else wc <= wc + 1;
    end else mem_ack <= 1'b0;
  end

  // Done log and request-hold monitor
  always @(posedge clk) begin
    if (done) begin
      dl[nd % LOGN] <= done_idx;
      nd <= nd + 1;
    end
    if (!rst && pv_req && !pv_ack &&
        (!mem_req || mem_addr != pv_addr || mem_we != pv_we || mem_wdata != pv_wd))
      hold_err <= hold_err + 1;
    pv_req <= mem_req; pv_ack <= mem_ack; pv_we <= mem_we;
    pv_addr <= mem_addr; pv_wd <= mem_wdata;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input int idx);
    @(negedge clk);
    start_vld = 1'b1;
    start_idx = 3'(idx);
    @(negedge clk);
    start_vld = 1'b0;
  endtask

  task automatic run_one(input int ch, input int addr, input int cnt, input int dir);
    int r0, w0, m0, mw0, s0, n, eff;
    dsc[3*ch]   = 16'(addr);
    dsc[3*ch+1] = 16'(cnt);
    dsc[3*ch+2] = 16'(dir);
    r0 = nr; w0 = nw; m0 = nmr; mw0 = nmw; s0 = int'(seq[ch]);
    eff = (ch == 4) ? 0 : dir;
    kick(ch);
    n = 1;
    while (!done && n < 300) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk("R7 done_idx", int'(done_idx), ch);
    chk("R2 desc word0", int'(rd_a[r0 % LOGN]), 3*ch);
    chk("R2 desc word1", int'(rd_a[(r0+1) % LOGN]), 3*ch+1);
    chk("R2 desc word2", int'(rd_a[(r0+2) % LOGN]), 3*ch+2);
    if (cnt == 0) begin
      chk("R5 zero-count latency", n, 5);
      chk("R5 zero-count mem cycles", (nmr - m0) + (nmw - mw0), 0);
    end
    @(negedge clk);
    chk("R7 done pulse width", int'(done), 0);
    chk("R7 busy after done", int'(busy), 0);
    if (eff == 0) begin
      chk(ch == 4 ? "R6 prog-load reads" : "R3 mem reads", nmr - m0, cnt);
      chk("R3 window writes", nw - w0, cnt);
      chk("R4 no mem writes on read dir", nmw - mw0, 0);
      for (int k = 0; k < cnt; k++) begin
        chk("R3 window addr", int'(wl_a[(w0+k) % LOGN]), 32 + ch);
        chk("R3 window data", int'(wl_d[(w0+k) % LOGN]), int'(ext_word(16'(addr + k))));
      end
    end else begin
      chk("R4 mem writes", nmw - mw0, cnt);
      chk("R4 no window writes", nw - w0, 0);
      for (int k = 0; k < cnt; k++) begin
        chk("R4 mem addr", int'(mw_a[(mw0+k) % LOGN]), addr + k);
        chk("R4 mem data", int'(mw_d[(mw0+k) % LOGN]), int'(win_word(ch, s0 + k)));
      end
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int d0, w0, cnts[3];
    for (int i = 0; i < 16; i++) dsc[i] = '0;
    cnts[0] = 0; cnts[1] = 1; cnts[2] = 4;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 mem_req in reset", int'(mem_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 sp strobes", int'(sp_rd) + int'(sp_wr), 0);
    chk("R1 mem_req", int'(mem_req), 0);

    // R10: out-of-range indices
    d0 = nd;
    for (int bad = 5; bad < 8; bad++) begin
      kick(bad);
      repeat (8) @(negedge clk);
      chk("R10 busy after bad index", int'(busy), 0);
      chk("R10 no completion", nd - d0, 0);
    end

    // Sweep: every channel, count, direction word, ack delay
    for (int ch = 0; ch < 5; ch++)
      for (int ci = 0; ci < 3; ci++)
        for (int dir = 0; dir < 2; dir++) begin
          lat = (ch + ci + dir) % 3;
          run_one(ch, 16'h40 + ch*16 + ci*5, cnts[ci], dir);
        end

    // R8/R9: queued starts, lowest index first, no interleaving
    dsc[12] = 16'h90; dsc[13] = 16'd2; dsc[14] = 16'd1;
    dsc[0]  = 16'hA0; dsc[1]  = 16'd1; dsc[2]  = 16'd0;
    dsc[6]  = 16'hB0; dsc[7]  = 16'd2; dsc[8]  = 16'd0;
    lat = 1;
    d0 = nd; w0 = nw;
    kick(4);
    start_vld = 1'b1; start_idx = 3'd2;
    @(negedge clk);
    start_idx = 3'd0;
    @(negedge clk);
    start_vld = 1'b0;
    for (int t = 0; t < 400 && nd < d0 + 3; t++) @(negedge clk);
    chk("R8 completions", nd - d0, 3);
    chk("R8 first done", int'(dl[d0 % LOGN]), 4);
    chk("R8 second done lowest", int'(dl[(d0+1) % LOGN]), 0);
    chk("R8 third done", int'(dl[(d0+2) % LOGN]), 2);
    chk("R9 window writes total", nw - w0, 5);
    for (int k = 0; k < 5; k++)
      chk("R9 window order", int'(wl_a[(w0+k) % LOGN]), (k < 2) ? 36 : (k < 3) ? 32 : 34);

    repeat (4) @(negedge clk);
    chk("R11 request hold violations", hold_err, 0);
    summary();
  end

endmodule